// File: doc/BRIEF.md
# Pipelined Control Carrier with Bubble Insertion

This block moves the decoded control bundle of an in-order five-stage pipeline from the decode stage to the stages that consume it. Decode presents the whole control word for one instruction in a single cycle. The block latches it into the decode/execute register. The execute group is presented to the datapath from there. The memory and write-back groups move on through the execute/memory register. The write-back group alone travels into the memory/write-back register. Each downstream stage sees only its own group.

A stall request from an external hazard detector is sampled at the clock edge. While the request is high, the program-counter write enable and the fetch/decode register write enable are both low, so fetch and decode hold and present the same instruction again. A no-operation bubble enters the decode/execute register instead of the decode word. Under the default setting the bubble zeroes every field. An alternative setting zeroes only the bits that change machine state (memory store, branch, register-file write) and lets the steering fields pass unchanged. The all-zero word is the no-operation encoding, and reset loads it into every stage register.

Top module: `ctl_pipe_carrier`

## Requirements
- R1: While reset is asserted, every execute, memory and write-back control output is 0.
- R2: `pc_we` and `ifid_we` are both 1 in a cycle where `stall` is 0, and both 0 in a cycle where `stall` is 1.
- R3: If `stall` is 0 at an edge, the execute outputs after that edge equal the decode inputs sampled at that edge.
- R4: The memory outputs (`mem_store_en`, `mem_is_br`) equal the memory-group decode inputs accepted two edges earlier.
- R5: The write-back outputs (`wb_load_sel`, `wb_rf_we`) equal the write-back-group decode inputs accepted three edges earlier.
- R6: With BUBBLE_MODE=1, a stall sampled at edge n gives all-zero execute outputs after edge n, all-zero memory outputs after edge n+1 and all-zero write-back outputs after edge n+2.
- R7: In either mode, a stall sampled at edge n gives `mem_store_en`=0 and `mem_is_br`=0 after edge n+1, and `wb_rf_we`=0 after edge n+2.
- R8: With BUBBLE_MODE=0, a bubble carries the stalled decode word's `ex_imm_sext`, `ex_opb_imm`, `ex_alu_fn`, `ex_dst_rd` and `wb_load_sel` unchanged.
- R9: A stall held for k edges places k consecutive bubbles. The decode word held during the stall then enters at the first edge without a stall and reaches each stage in order.
- R10: `id_alu_fn` and `ex_alu_fn` are OP_W bits wide, and all OP_W bits are carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Hold fetch/decode and insert a bubble |
| id_imm_sext | input | 1 | Decode: immediate sign-extend select |
| id_opb_imm | input | 1 | Decode: ALU second operand from immediate |
| id_alu_fn | input | OP_W | Decode: ALU function |
| id_dst_rd | input | 1 | Decode: destination register field select |
| id_store_en | input | 1 | Decode: data memory store |
| id_is_br | input | 1 | Decode: conditional branch |
| id_load_sel | input | 1 | Decode: write-back takes memory data |
| id_rf_we | input | 1 | Decode: register file write |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_imm_sext | output | 1 | Execute: immediate sign-extend select |
| ex_opb_imm | output | 1 | Execute: second operand from immediate |
| ex_alu_fn | output | OP_W | Execute: ALU function |
| ex_dst_rd | output | 1 | Execute: destination select |
| mem_store_en | output | 1 | Memory: store enable |
| mem_is_br | output | 1 | Memory: branch |
| wb_load_sel | output | 1 | Write-back: memory data select |
| wb_rf_we | output | 1 | Write-back: register file write |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One copy uses the defaults (OP_W=2, BUBBLE_MODE=1), so every bubble is checked as an all-zero word at each stage. The other uses OP_W=4 with BUBBLE_MODE=0, which exposes the upper function bits that the narrow copy drops and shows the steering fields passing through a bubble while the store, branch and write bits are cleared. A two-edge stall followed by release checks bubble spacing, the write-back suppression three cycles later and the re-issue order in both copies.

// File: rtl/ctl_pipe_pkg.sv
package ctl_pipe_pkg;

   typedef struct packed {
      logic wr_mem;
      logic is_branch;
   } mem_grp_t;

   typedef struct packed {
      logic sel_load;
      logic wr_reg;
   } wb_grp_t;

   localparam int MEM_GRP_W   = $bits(mem_grp_t);
   localparam int WB_GRP_W    = $bits(wb_grp_t);
   // single-bit steering fields of the execute group besides the ALU function
   localparam int EX_FIXED_W  = 3;

endpackage

// File: rtl/ctl_hold_unit.sv
module ctl_hold_unit (
   input  logic stall,
   output logic pc_we,
   output logic ifid_we,
   output logic bubble
);
   // front-end freeze and bubble request share one cause
   assign pc_we   = ~stall;
   assign ifid_we = ~stall;
   assign bubble  = stall;
endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (W >= 1) else $error("ctl_stage_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/ctl_bubble_mux.sv
module ctl_bubble_mux
   import ctl_pipe_pkg::*;
#(
   parameter int OP_W        = 2,
   parameter int BUBBLE_MODE = 1
) (
   input  logic                      bubble,
   input  logic [OP_W+EX_FIXED_W-1:0] ex_in,
   input  mem_grp_t                  mem_in,
   input  wb_grp_t                   wb_in,
   output logic [OP_W+EX_FIXED_W-1:0] ex_out,
   output mem_grp_t                  mem_out,
   output wb_grp_t                   wb_out
);
   generate
      if (BUBBLE_MODE == 1) begin : g_zero_all
         always_comb begin
            ex_out  = bubble ? '0 : ex_in;
            mem_out = bubble ? '0 : mem_in;
            wb_out  = bubble ? '0 : wb_in;
         end
      end else begin : g_zero_enables
         always_comb begin
            ex_out  = ex_in;
            mem_out = mem_in;
            wb_out  = wb_in;
            if (bubble) begin
               mem_out.wr_mem    = 1'b0;
               mem_out.is_branch = 1'b0;
               wb_out.wr_reg     = 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ctl_pipe_carrier.sv
module ctl_pipe_carrier
   import ctl_pipe_pkg::*;
#(
   parameter int OP_W        = 2,
   parameter int BUBBLE_MODE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall,
   input  logic            id_imm_sext,
   input  logic            id_opb_imm,
   input  logic [OP_W-1:0] id_alu_fn,
   input  logic            id_dst_rd,
   input  logic            id_store_en,
   input  logic            id_is_br,
   input  logic            id_load_sel,
   input  logic            id_rf_we,
   output logic            pc_we,
   output logic            ifid_we,
   output logic            ex_imm_sext,
   output logic            ex_opb_imm,
   output logic [OP_W-1:0] ex_alu_fn,
   output logic            ex_dst_rd,
   output logic            mem_store_en,
   output logic            mem_is_br,
   output logic            wb_load_sel,
   output logic            wb_rf_we
);
   localparam int EXW     = OP_W + EX_FIXED_W;
   localparam int IDEX_W  = EXW + MEM_GRP_W + WB_GRP_W;
   localparam int EXMEM_W = MEM_GRP_W + WB_GRP_W;

   initial begin
      assert (OP_W >= 1 && OP_W <= 8)
         else $error("ctl_pipe_carrier: OP_W out of range 1..8");
      assert (BUBBLE_MODE == 0 || BUBBLE_MODE == 1)
         else $error("ctl_pipe_carrier: BUBBLE_MODE must be 0 or 1");
   end

   logic               bubble;
   logic [EXW-1:0]     ex_dec, ex_gated, idex_ex;
   mem_grp_t           mem_dec, mem_gated, idex_mem, exmem_mem;
   wb_grp_t            wb_dec, wb_gated, idex_wb, exmem_wb, memwb_wb;
   logic [IDEX_W-1:0]  idex_q;
   logic [EXMEM_W-1:0] exmem_q;
   logic [WB_GRP_W-1:0] memwb_q;

   // control word as produced once in decode
   assign ex_dec            = {id_imm_sext, id_opb_imm, id_alu_fn, id_dst_rd};
   assign mem_dec.wr_mem    = id_store_en;
   assign mem_dec.is_branch = id_is_br;
   assign wb_dec.sel_load   = id_load_sel;
   assign wb_dec.wr_reg     = id_rf_we;

   ctl_hold_unit u_hold (
      .stall   (stall),
      .pc_we   (pc_we),
      .ifid_we (ifid_we),
      .bubble  (bubble)
   );

   ctl_bubble_mux #(.OP_W(OP_W), .BUBBLE_MODE(BUBBLE_MODE)) u_bubble (
      .bubble  (bubble),
      .ex_in   (ex_dec),
      .mem_in  (mem_dec),
      .wb_in   (wb_dec),
      .ex_out  (ex_gated),
      .mem_out (mem_gated),
      .wb_out  (wb_gated)
   );

   // decode/execute: full bundle
   ctl_stage_reg #(.W(IDEX_W)) u_idex (
      .clk (clk), .rst_n (rst_n),
      .d   ({ex_gated, mem_gated, wb_gated}),
      .q   (idex_q)
   );
   assign idex_ex  = idex_q[IDEX_W-1 -: EXW];
   assign idex_mem = idex_q[EXMEM_W-1 -: MEM_GRP_W];
   assign idex_wb  = idex_q[WB_GRP_W-1:0];

   // execute/memory: execute group dropped
   ctl_stage_reg #(.W(EXMEM_W)) u_exmem (
      .clk (clk), .rst_n (rst_n),
      .d   ({idex_mem, idex_wb}),
      .q   (exmem_q)
   );
   assign exmem_mem = exmem_q[EXMEM_W-1 -: MEM_GRP_W];
   assign exmem_wb  = exmem_q[WB_GRP_W-1:0];

   // memory/write-back: write-back group only
   ctl_stage_reg #(.W(WB_GRP_W)) u_memwb (
      .clk (clk), .rst_n (rst_n),
      .d   (exmem_wb),
      .q   (memwb_q)
   );
   assign memwb_wb = memwb_q;

   assign {ex_imm_sext, ex_opb_imm, ex_alu_fn, ex_dst_rd} = idex_ex;
   assign mem_store_en = exmem_mem.wr_mem;
   assign mem_is_br    = exmem_mem.is_branch;
   assign wb_load_sel  = memwb_wb.sel_load;
   assign wb_rf_we     = memwb_wb.wr_reg;

   // ---------------- assertions ----------------
   p_reset_clear_r1: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n)) |->
         (ex_alu_fn == '0 && !ex_imm_sext && !ex_opb_imm && !ex_dst_rd &&
          !mem_store_en && !mem_is_br && !wb_load_sel && !wb_rf_we));

   p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!pc_we && !ifid_we));

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |-> (pc_we && ifid_we));

   p_ex_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(stall)) |->
         (ex_alu_fn == $past(id_alu_fn) && ex_imm_sext == $past(id_imm_sext) &&
          ex_opb_imm == $past(id_opb_imm) && ex_dst_rd == $past(id_dst_rd)));

   p_mem_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ({mem_store_en, mem_is_br} == $past(idex_mem)));

   p_wb_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ({wb_load_sel, wb_rf_we} == $past(exmem_wb)));

   p_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stall, 2) |-> (!mem_store_en && !mem_is_br));

   p_no_rf_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stall, 3) |-> !wb_rf_we);

   generate
      if (BUBBLE_MODE == 1) begin : g_chk_zero
         p_bubble_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(stall)) |->
               (idex_ex == '0 && idex_mem == '0 && idex_wb == '0));
      end else begin : g_chk_keep
         p_bubble_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(stall)) |->
               (ex_alu_fn == $past(id_alu_fn) && ex_dst_rd == $past(id_dst_rd) &&
                idex_wb.sel_load == $past(id_load_sel) && !idex_wb.wr_reg));
      end
   endgenerate

endmodule

// File: tb/test_ctl_pipe_carrier.sv
module test_ctl_pipe_carrier;

   localparam time PERIOD = 8ns;

   typedef struct packed {
      logic       ext;
      logic       src;
      logic [3:0] op;
      logic       dst;
      logic       mwr;
      logic       br;
      logic       m2r;
      logic       rwr;
   } word_t;

   logic  clk = 1'b0;
   logic  rst_n = 1'b0;
   logic  stall = 1'b0;
   word_t dw = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic       a_pcwe, a_ifwe, a_ext, a_src, a_dst, a_mwr, a_br, a_m2r, a_rwr;
   logic [1:0] a_op;
   logic       b_pcwe, b_ifwe, b_ext, b_src, b_dst, b_mwr, b_br, b_m2r, b_rwr;
   logic [3:0] b_op;

   always #(PERIOD/2) clk = ~clk;

   ctl_pipe_carrier i_ctl_pipe_carrier (
      .clk (clk), .rst_n (rst_n), .stall (stall),
      .id_imm_sext (dw.ext), .id_opb_imm (dw.src), .id_alu_fn (dw.op[1:0]),
      .id_dst_rd (dw.dst), .id_store_en (dw.mwr), .id_is_br (dw.br),
      .id_load_sel (dw.m2r), .id_rf_we (dw.rwr),
      .pc_we (a_pcwe), .ifid_we (a_ifwe),
      .ex_imm_sext (a_ext), .ex_opb_imm (a_src), .ex_alu_fn (a_op), .ex_dst_rd (a_dst),
      .mem_store_en (a_mwr), .mem_is_br (a_br),
      .wb_load_sel (a_m2r), .wb_rf_we (a_rwr)
   );

   ctl_pipe_carrier #(.OP_W(4), .BUBBLE_MODE(0)) i_ctl_pipe_carrier_keep (
      .clk (clk), .rst_n (rst_n), .stall (stall),
      .id_imm_sext (dw.ext), .id_opb_imm (dw.src), .id_alu_fn (dw.op),
      .id_dst_rd (dw.dst), .id_store_en (dw.mwr), .id_is_br (dw.br),
      .id_load_sel (dw.m2r), .id_rf_we (dw.rwr),
      .pc_we (b_pcwe), .ifid_we (b_ifwe),
      .ex_imm_sext (b_ext), .ex_opb_imm (b_src), .ex_alu_fn (b_op), .ex_dst_rd (b_dst),
      .mem_store_en (b_mwr), .mem_is_br (b_br),
      .wb_load_sel (b_m2r), .wb_rf_we (b_rwr)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R8 expectation: only store, branch and register write cleared
   function automatic word_t keep_bubble(input word_t w);
      word_t r = w;
      r.mwr = 1'b0; r.br = 1'b0; r.rwr = 1'b0;
      return r;
   endfunction

   // stage 1 = execute, 2 = memory, 3 = write-back
   task automatic check_stage(input string r, input int s, input word_t ea, input word_t eb);
      case (s)
         1: begin
            chk({r, " ex narrow"}, {3'b0, a_ext, a_src, a_op, a_dst},
                {3'b0, ea.ext, ea.src, ea.op[1:0], ea.dst});
            chk({r, " ex wide R10"}, {1'b0, b_ext, b_src, b_op, b_dst},
                {1'b0, eb.ext, eb.src, eb.op, eb.dst});
         end
         2: begin
            chk({r, " mem narrow"}, {6'b0, a_mwr, a_br}, {6'b0, ea.mwr, ea.br});
            chk({r, " mem wide"},   {6'b0, b_mwr, b_br}, {6'b0, eb.mwr, eb.br});
         end
         default: begin
            chk({r, " wb narrow"}, {6'b0, a_m2r, a_rwr}, {6'b0, ea.m2r, ea.rwr});
            chk({r, " wb wide"},   {6'b0, b_m2r, b_rwr}, {6'b0, eb.m2r, eb.rwr});
         end
      endcase
   endtask

   // drive at a falling edge, check enables, advance one full cycle
   task automatic apply(input word_t w, input logic st);
      dw    = w;
      stall = st;
      #1;
      chk("R2 pc_we narrow",   {7'b0, a_pcwe}, {7'b0, ~st});
      chk("R2 ifid_we narrow", {7'b0, a_ifwe}, {7'b0, ~st});
      chk("R2 pc_we wide",     {7'b0, b_pcwe}, {7'b0, ~st});
      chk("R2 ifid_we wide",   {7'b0, b_ifwe}, {7'b0, ~st});
      @(negedge clk);
   endtask

   task automatic t_reset_idle();
      #1;
      for (int s = 1; s <= 3; s++) check_stage("R1 reset idle", s, '0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_flow();
      word_t w1 = '{ext:1'b1, src:1'b0, op:4'hA, dst:1'b1, mwr:1'b0, br:1'b1, m2r:1'b1, rwr:1'b0};
      word_t w2 = '{ext:1'b0, src:1'b1, op:4'h5, dst:1'b0, mwr:1'b1, br:1'b0, m2r:1'b0, rwr:1'b1};
      word_t w3 = '{ext:1'b1, src:1'b1, op:4'h3, dst:1'b0, mwr:1'b1, br:1'b1, m2r:1'b1, rwr:1'b1};
      apply(w1, 1'b0);
      check_stage("R3 w1", 1, w1, w1);
      apply(w2, 1'b0);
      check_stage("R3 w2", 1, w2, w2);
      check_stage("R4 w1", 2, w1, w1);
      apply(w3, 1'b0);
      check_stage("R3 w3", 1, w3, w3);
      check_stage("R4 w2", 2, w2, w2);
      check_stage("R5 w1", 3, w1, w1);
      apply('0, 1'b0);
      check_stage("R4 w3", 2, w3, w3);
      check_stage("R5 w2", 3, w2, w2);
      apply('0, 1'b0);
      check_stage("R5 w3", 3, w3, w3);
   endtask

   task automatic t_stall_two();
      word_t x  = '1;
      word_t xb = keep_bubble(x);
      apply(x, 1'b1);                       // bubble 1
      check_stage("R6 R8 bubble1 ex", 1, '0, xb);
      apply(x, 1'b1);                       // bubble 2
      check_stage("R9 bubble2 ex", 1, '0, xb);
      check_stage("R7 bubble1 mem", 2, '0, xb);
      apply(x, 1'b0);                       // held word enters
      check_stage("R9 reissue ex", 1, x, x);
      check_stage("R7 bubble2 mem", 2, '0, xb);
      check_stage("R7 R8 bubble1 wb", 3, '0, xb);
      apply('0, 1'b0);
      check_stage("R9 reissue mem", 2, x, x);
      check_stage("R7 bubble2 wb", 3, '0, xb);
      apply('0, 1'b0);
      check_stage("R9 reissue wb", 3, x, x);
   endtask

   task automatic t_reset_busy();
      word_t x = '1;
      apply(x, 1'b0);
      apply(x, 1'b0);
      apply(x, 1'b0);
      check_stage("R5 full before reset", 3, x, x);
      rst_n = 1'b0;
      #1;
      for (int s = 1; s <= 3; s++) check_stage("R1 reset busy", s, '0, '0);
      @(negedge clk);
      for (int s = 1; s <= 3; s++) check_stage("R1 reset held", s, '0, '0);
      dw    = '0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      t_reset_idle();
      t_flow();
      t_stall_two();
      t_reset_busy();
      t_flow();
      finish_run();
   end

endmodule